// File: doc/BRIEF.md
# Binary-Point Priority Preemption Unit

This block is the per-processor decision point of an interrupt controller. Every cycle it looks at a set of pending interrupt sources, each with an 8-bit priority, a group bit and a 10-bit identifier. It finds the most urgent one and decides whether that source may interrupt the processor now. Three things can stop it: a priority mask, the nesting depth, and the priority of the handler already running. A programmable binary point splits each priority into a preemption part and a tie-break part, so only the upper field decides preemption. Group 0 sources are raised on a fast-interrupt line and group 1 sources on the normal interrupt line.

Software, or a sequencer, takes the interrupt with a one-cycle acknowledge strobe. The strobe returns the winning identifier and pushes its preemption priority onto a small stack of running priorities. An end-of-interrupt strobe pops that stack and restores the priority that was running before. Group 1 priorities keep fewer implemented bits than group 0 priorities. The unused low bits are treated as zero throughout.

Top module: `prio_preempt_unit`

## Requirements
- R1: A smaller priority number is more urgent. The selected source is the pending, non-reserved source with the smallest implemented priority. Among equal priorities the smallest identifier wins. `hp_id_o` shows its identifier, or 1023 when no source qualifies.
- R2: Implemented priority keeps only the top `G1_BITS+1` bits of a group 0 priority and the top `G1_BITS` bits of a group 1 priority, with the other bits taken as zero. `grp_i` bit 0 selects group 0 and bit 1 selects group 1. The default `G1_BITS` is 4.
- R3: A source can be signalled only when its implemented priority is numerically below `mask_i`. A mask of 0 blocks every source.
- R4: While at least one handler is running, the selected source preempts only if its preemption field is strictly smaller than `run_prio_o`. For binary point N in 0 to 6, the preemption field is the implemented priority with bits [N:0] cleared. Bits [N:0] only break ties.
- R5: With binary point 7 nothing preempts a running handler. A source can be signalled only when the stack is empty.
- R6: An eligible group 0 winner raises `fiq_o` and an eligible group 1 winner raises `irq_o`. The two lines are never high together.
- R7: An acknowledge while a line is raised loads the winner's identifier into `ack_id_o` on the next cycle. It also pushes the winner's preemption field onto the stack, which is 0x00 under binary point 7. `run_prio_o` then shows that value.
- R8: An acknowledge while neither line is raised loads 1023 into `ack_id_o` and leaves the stack unchanged.
- R9: End-of-interrupt pops the stack. `run_prio_o` then shows the entry below, or 0xFF when the stack is empty. End-of-interrupt on an empty stack has no effect.
- R10: When the stack holds `STACK_DEPTH` entries, neither line is raised and acknowledges return 1023.
- R11: A source whose identifier is 1020 to 1023 is never selected.
- R12: When acknowledge and end-of-interrupt arrive in the same cycle, the acknowledge is handled and the end-of-interrupt is ignored.
- R13: After reset `run_prio_o` is 0xFF, `ack_id_o` is 1023 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_SRC | Pending flag per source |
| prio_i | input | NUM_SRC*8 | Priority per source, source i in bits [8i+7:8i] |
| grp_i | input | NUM_SRC | Group per source, 0 = group 0, 1 = group 1 |
| id_i | input | NUM_SRC*ID_W | Identifier per source |
| mask_i | input | 8 | Priority mask |
| bpoint_i | input | 3 | Binary point, 0 to 7 |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| fiq_o | output | 1 | Fast-interrupt request (group 0) |
| irq_o | output | 1 | Interrupt request (group 1) |
| hp_id_o | output | ID_W | Highest pending identifier, or 1023 |
| ack_id_o | output | ID_W | Identifier returned by the last acknowledge |
| run_prio_o | output | 8 | Running priority, 0xFF when idle |

## Verification
The bench builds the unit with six sources, a stack depth of three and the default four implemented group 1 bits. The shallow stack lets random acknowledge bursts fill it within a few cycles, so the full-stack refusal and the spurious acknowledges are reached often. Six sources with unique identifiers give frequent priority ties and occasional reserved identifiers. A random binary point, including 7, exercises every split between preemption field and tie-break field against a running stack.

// File: rtl/ppu_pkg.sv
package ppu_pkg;
  localparam int PW = 8;
  localparam logic [PW-1:0] IDLE_PRIO = 8'hFF;

  // Keep the implemented priority bits: group 0 keeps one more bit.
  function automatic logic [PW-1:0] impl_prio(input logic [PW-1:0] p,
                                              input logic grp,
                                              input int unsigned g1_bits);
    int unsigned keep;
    logic [PW-1:0] m;
    keep = grp ? g1_bits : g1_bits + 1;
    m = 8'hFF << (PW - keep);
    return p & m;
  endfunction

  // Preemption field: priority with bits [bp:0] cleared; bp 7 leaves none.
  function automatic logic [PW-1:0] grp_part(input logic [PW-1:0] p,
                                             input logic [2:0] bp);
    logic [3:0] sh;
    if (bp == 3'd7) return '0;
    sh = {1'b0, bp} + 4'd1;
    return p & (8'hFF << sh);
  endfunction
endpackage

// File: rtl/ppu_src_filter.sv
module ppu_src_filter
  import ppu_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 10,
  parameter int G1_BITS = 4
) (
  input  logic [NUM_SRC-1:0]      pend,
  input  logic [NUM_SRC*PW-1:0]   prio,
  input  logic [NUM_SRC-1:0]      grp,
  input  logic [NUM_SRC*ID_W-1:0] id,
  output logic [NUM_SRC-1:0]      valid,
  output logic [NUM_SRC*PW-1:0]   eff
);
  localparam logic [ID_W-1:0] RES_BASE = {ID_W{1'b1}} - ID_W'(3);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign eff[i*PW +: PW] = impl_prio(prio[i*PW +: PW], grp[i], G1_BITS);
    assign valid[i]        = pend[i] && (id[i*ID_W +: ID_W] < RES_BASE);
  end
endmodule

// File: rtl/ppu_arbiter.sv
module ppu_arbiter
  import ppu_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      valid,
  input  logic [NUM_SRC*PW-1:0]   eff,
  input  logic [NUM_SRC*ID_W-1:0] id,
  input  logic [NUM_SRC-1:0]      grp,
  output logic                    found,
  output logic [PW-1:0]           win_prio,
  output logic [ID_W-1:0]         win_id,
  output logic                    win_grp
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ID_W-1:0] RES_BASE = {ID_W{1'b1}} - ID_W'(3);

  logic [IW-1:0] win_idx;

  always_comb begin
    found    = 1'b0;
    win_prio = IDLE_PRIO;
    win_id   = '1;
    win_idx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (valid[i] && (!found || (eff[i*PW +: PW] < win_prio) ||
          ((eff[i*PW +: PW] == win_prio) && (id[i*ID_W +: ID_W] < win_id)))) begin
        found    = 1'b1;
        win_prio = eff[i*PW +: PW];
        win_id   = id[i*ID_W +: ID_W];
        win_idx  = IW'(i);
      end
    end
  end

  assign win_grp = grp[win_idx];

  // The winner is always one of the qualified sources.
  assert_winner_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> valid[win_idx]);
  // Reserved identifiers never win.
  assert_no_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (win_id < RES_BASE));
endmodule

// File: rtl/ppu_run_stack.sv
module ppu_run_stack
  import ppu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] push_val,
  output logic [PW-1:0] run_prio,
  output logic          full,
  output logic          empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]    stk [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_idx;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign top_idx = cnt - CNT_W'(1);
  assign run_prio = empty ? IDLE_PRIO : stk[top_idx[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      stk[cnt[IDX_W-1:0]] <= push_val;
      cnt <= cnt + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_push_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (run_prio == $past(push_val)));
  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
endmodule

// File: rtl/prio_preempt_unit.sv
module prio_preempt_unit
  import ppu_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int ID_W        = 10,
  parameter int G1_BITS     = 4,
  parameter int STACK_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      pend_i,
  input  logic [NUM_SRC*8-1:0]    prio_i,
  input  logic [NUM_SRC-1:0]      grp_i,
  input  logic [NUM_SRC*ID_W-1:0] id_i,
  input  logic [7:0]              mask_i,
  input  logic [2:0]              bpoint_i,
  input  logic                    ack_i,
  input  logic                    eoi_i,
  output logic                    fiq_o,
  output logic                    irq_o,
  output logic [ID_W-1:0]         hp_id_o,
  output logic [ID_W-1:0]         ack_id_o,
  output logic [7:0]              run_prio_o
);
  localparam logic [ID_W-1:0] SPUR_ID = {ID_W{1'b1}};

  logic [NUM_SRC-1:0]    src_valid;
  logic [NUM_SRC*PW-1:0] src_eff;
  logic                  found;
  logic [PW-1:0]         win_prio;
  logic [ID_W-1:0]       win_id;
  logic                  win_grp;
  logic                  stk_full, stk_empty;
  logic                  below_mask, may_preempt, signal_ok;
  logic                  do_push, do_pop;
  logic [PW-1:0]         win_field;

  ppu_src_filter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .G1_BITS(G1_BITS)) u_filter (
    .pend(pend_i), .prio(prio_i), .grp(grp_i), .id(id_i),
    .valid(src_valid), .eff(src_eff));

  ppu_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .valid(src_valid), .eff(src_eff), .id(id_i),
    .grp(grp_i), .found(found), .win_prio(win_prio), .win_id(win_id),
    .win_grp(win_grp));

  // Eligibility: mask, nesting room, and preemption field against running.
  assign win_field   = grp_part(win_prio, bpoint_i);
  assign below_mask  = win_prio < mask_i;
  assign may_preempt = stk_empty || ((bpoint_i != 3'd7) && (win_field < run_prio_o));
  assign signal_ok   = found && below_mask && !stk_full && may_preempt;

  assign fiq_o   = signal_ok && !win_grp;
  assign irq_o   = signal_ok && win_grp;
  assign hp_id_o = found ? win_id : SPUR_ID;

  assign do_push = ack_i && signal_ok;
  assign do_pop  = eoi_i && !ack_i;

  ppu_run_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
    .push_val(win_field), .run_prio(run_prio_o),
    .full(stk_full), .empty(stk_empty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ack_id_o <= SPUR_ID;
    else if (ack_i) ack_id_o <= signal_ok ? win_id : SPUR_ID;
  end

  assert_one_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fiq_o, irq_o}));
  assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o || irq_o) |-> (win_prio < mask_i));
  assert_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !fiq_o && !irq_o) |=> (ack_id_o == SPUR_ID));
  assert_no_preempt_bp7_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((bpoint_i == 3'd7) && (run_prio_o != IDLE_PRIO)) |-> !(fiq_o || irq_o));
  assert_ack_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && eoi_i && (fiq_o || irq_o)) |=> (run_prio_o != IDLE_PRIO));
endmodule

// File: tb/sim_prio_preempt_unit.sv
`timescale 1ns/1ps
module sim_prio_preempt_unit;
  localparam int NS = 6;
  localparam int IDW = 10;
  localparam int G1 = 4;
  localparam int SD = 3;
  localparam int SPUR = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] pend = '0;
  logic [NS*8-1:0] prio = '0;
  logic [NS-1:0] grp = '0;
  logic [NS*IDW-1:0] ids = '0;
  logic [7:0] mask = 8'hFF;
  logic [2:0] bp = 3'd0;
  logic ack = 1'b0, eoi = 1'b0;
  logic fiq, irq;
  logic [IDW-1:0] hp_id, ack_id;
  logic [7:0] run_prio;

  int total = 0, bad = 0;
  int mstk [SD];
  int mcnt = 0;
  int exp_ack = SPUR;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_preempt_unit #(.NUM_SRC(NS), .ID_W(IDW), .G1_BITS(G1), .STACK_DEPTH(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio), .grp_i(grp),
    .id_i(ids), .mask_i(mask), .bpoint_i(bp), .ack_i(ack), .eoi_i(eoi),
    .fiq_o(fiq), .irq_o(irq), .hp_id_o(hp_id), .ack_id_o(ack_id),
    .run_prio_o(run_prio));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_impl(int p, int g);
    int keep = (g != 0) ? G1 : G1 + 1;
    return p & ~(255 >> keep) & 255;
  endfunction

  function automatic int m_field(int p, int b);
    if (b == 7) return 0;
    return p & ~((1 << (b + 1)) - 1) & 255;
  endfunction

  function automatic int m_run();
    return (mcnt == 0) ? 255 : mstk[mcnt-1];
  endfunction

  // Returns winner index or -1.
  function automatic int m_winner();
    int best = -1;
    int bkey = 0;
    for (int i = 0; i < NS; i++) begin
      int id_v = int'(ids[i*IDW +: IDW]);
      int key = m_impl(int'(prio[i*8 +: 8]), int'(grp[i])) * 2048 + id_v;
      if (pend[i] && id_v < 1020 && (best < 0 || key < bkey)) begin
        best = i;
        bkey = key;
      end
    end
    return best;
  endfunction

  function automatic bit m_elig(int w);
    int p;
    if (w < 0) return 0;
    p = m_impl(int'(prio[w*8 +: 8]), int'(grp[w]));
    if (p >= int'(mask)) return 0;
    if (mcnt == SD) return 0;
    if (mcnt == 0) return 1;
    return (bp != 3'd7) && (m_field(p, int'(bp)) < m_run());
  endfunction

  // Inputs already driven; check outputs, then apply the strobes to the model.
  task automatic eval_cycle();
    int w;
    bit el;
    #1;
    w  = m_winner();
    el = m_elig(w);
    check("R1 R2 R11 hp_id", int'(hp_id), (w < 0) ? SPUR : int'(ids[w*IDW +: IDW]));
    check("R3 R4 R5 R6 R10 fiq", int'(fiq), int'(el && grp[w] == 1'b0));
    check("R3 R4 R5 R6 R10 irq", int'(irq), int'(el && grp[w] == 1'b1));
    if (ack) begin
      exp_ack = el ? int'(ids[w*IDW +: IDW]) : SPUR;
      if (el) begin
        mstk[mcnt] = m_field(m_impl(int'(prio[w*8 +: 8]), int'(grp[w])), int'(bp));
        mcnt++;
      end
    end else if (eoi && mcnt > 0) begin
      mcnt--;
    end
  endtask

  task automatic check_regs(input string tag);
    check({tag, " R7 R8 R12 ack_id"}, int'(ack_id), exp_ack);
    check({tag, " R9 R12 run_prio"}, int'(run_prio), m_run());
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1;
    check("R13 run_prio", int'(run_prio), 255);
    check("R13 ack_id", int'(ack_id), SPUR);
    check("R1 empty hp_id", int'(hp_id), SPUR);
    rst_n = 1'b1;

    // R2: group 1 raw 0x1F truncates to 0x10, beats group 0 raw 0x18.
    @(negedge clk);
    pend = 6'b000011;
    prio[7:0] = 8'h18; grp[0] = 1'b0; ids[0 +: IDW] = 10'd5;
    prio[15:8] = 8'h1F; grp[1] = 1'b1; ids[IDW +: IDW] = 10'd9;
    eval_cycle();
    check("R2 directed irq", int'(irq), 1);

    // R11: reserved id with priority 0 is passed over.
    @(negedge clk);
    prio[7:0] = 8'h00; ids[0 +: IDW] = 10'd1021;
    eval_cycle();
    check("R11 directed hp_id", int'(hp_id), 9);

    // R12: ack and eoi together.
    @(negedge clk);
    ack = 1'b1; eoi = 1'b1;
    eval_cycle();
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0;
    check_regs("directed");

    // Random phase.
    for (int it = 0; it < 1500; it++) begin
      @(negedge clk);
      check_regs("random");
      for (int i = 0; i < NS; i++) begin
        pend[i] = ($urandom % 3) != 0;
        prio[i*8 +: 8] = ($urandom % 2 == 0) ? 8'($urandom % 4 * 32) : 8'($urandom);
        grp[i] = 1'($urandom);
        ids[i*IDW +: IDW] = (i < 4 && $urandom % 12 == 0) ? IDW'(1020 + i)
                                                          : IDW'(i + NS * ($urandom % 150));
      end
      mask = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
      bp   = 3'($urandom);
      ack  = ($urandom % 3) == 0;
      eoi  = ($urandom % 4) == 0;
      eval_cycle();
    end
    @(negedge clk);
    check_regs("final");
    ack = 1'b0; eoi = 1'b0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule